// File: doc/BRIEF.md
# Truncating Float-to-Signed-Integer Converter

This block turns a floating value that has already been unpacked into a class code, a sign, an unbiased exponent and a normalised mantissa into a two's-complement signed integer. It always truncates toward zero, whatever rounding mode the rest of the floating-point unit is using. Alongside the integer it reports two exception flags: inexact, raised when fraction bits were discarded, and invalid, raised when the value has no representable integer.

Out-of-range values, infinities and NaNs saturate according to their sign. A positive value gives the largest positive integer and a negative value gives the most negative integer. In that case invalid is raised and inexact is suppressed. The result width is a parameter, usually 32 or 64. One conversion is accepted per cycle when `in_valid` is high, and the registered result appears on the following cycle.

Top module: `fti_trunc_conv`

## Requirements
- R1: A conversion presented with `in_valid` high in cycle n appears on the outputs in cycle n+1 with `out_valid` high. `out_valid` is low in every cycle after one in which `in_valid` was low.
- R2: While `in_valid` is low, `out_result`, `out_inexact` and `out_invalid` keep their previous values, whatever the other inputs do.
- R3: A class code of 0 (zero) gives a result of 0 with both flags clear, for either sign and for any exponent or mantissa.
- R4: For class code 1 (finite, nonzero) with an in-range value, the input is worth `in_mant * 2^(in_exp - (MANT_W-1))`, with the leading 1 in mantissa bit MANT_W-1. The result is the floor of that magnitude, negated in two's complement when `in_sign` is 1.
- R5: For an in-range class-1 value, `out_inexact` is 1 exactly when the discarded fraction is nonzero. `out_invalid` is 0.
- R6: A class-1 value with a negative exponent, including one far below -MANT_W, gives result 0 with `out_inexact` set.
- R7: A class-1 value with `in_exp >= OUT_W` is an overflow.
- R8: A class-1 value whose truncated magnitude is at least 2^(OUT_W-1) + `in_sign` is an overflow. A negative magnitude of exactly 2^(OUT_W-1) converts without overflow.
- R9: An overflow gives 0x7F..F when `in_sign` is 0 and 0x80..0 when `in_sign` is 1, with `out_invalid` 1 and `out_inexact` 0.
- R10: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 give the R9 saturation value for the given sign, with `out_invalid` 1 and `out_inexact` 0.
- R11: While `rst_n` is low, and until the internal reset release completes, `out_valid`, `out_result` and both flags are 0.
- R12: `out_inexact` and `out_invalid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | Accept a conversion this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 finite, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Normalised mantissa, leading 1 in the top bit |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| out_result | output | OUT_W | Signed integer result |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Overflow or non-numeric input; result saturated |

## Verification
The embedded properties check the following on every clock:
- the one-cycle latency, and that results hold while idle;
- that zero-class inputs are quiet;
- that non-numeric classes always raise invalid;
- that a negative exponent yields zero with inexact;
- that every invalid result is one of the two saturation words;
- that the two flags are never raised together.

Only the bench's scenarios can show that the truncated magnitude, its negation and the inexact decision are arithmetically right. The same holds for where the overflow threshold falls around 2^(OUT_W-1) for each sign. The bench therefore sweeps the exponent across the full shift range for several mantissa patterns and both signs, and compares against an arithmetic model.

// File: rtl/fti_pkg.sv
package fti_pkg;

  typedef enum logic [2:0] {
    FTI_ZERO = 3'd0,
    FTI_FIN  = 3'd1,
    FTI_INF  = 3'd2,
    FTI_QNAN = 3'd3,
    FTI_SNAN = 3'd4
  } fti_class_e;

  function automatic int fti_shift_bits(input int mant_w);
    return $clog2(mant_w + 1);
  endfunction

endpackage

// File: rtl/fti_align_shift.sv
// Logarithmic right shifter that also ORs every bit it drops into a sticky flag.
module fti_align_shift #(
  parameter int MANT_W = 66,
  parameter int SH_W   = 7
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [MANT_W-1:0] shifted_o,
  output logic              sticky_o
);

  logic [MANT_W-1:0] stage [0:SH_W];
  logic [SH_W-1:0]   dropped;

  assign stage[0] = mant_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    if (STEP >= MANT_W) begin : g_full
      // A stage this wide clears the word outright.
      assign stage[k+1] = amt_i[k] ? '0 : stage[k];
      assign dropped[k] = amt_i[k] & (|stage[k]);
    end else begin : g_part
      assign stage[k+1] = amt_i[k] ? (stage[k] >> STEP) : stage[k];
      assign dropped[k] = amt_i[k] & (|stage[k][STEP-1:0]);
    end
  end

  assign shifted_o = stage[SH_W];
  assign sticky_o  = |dropped;

endmodule

// File: rtl/fti_range_chk.sv
// Decides whether the aligned magnitude fits the signed result.
module fti_range_chk #(
  parameter int OUT_W  = 32,
  parameter int MANT_W = 66,
  parameter int EXP_W  = 12
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic                    sign_i,
  input  logic [MANT_W-1:0]       shifted_i,
  output logic [OUT_W-1:0]        mag_o,
  output logic                    ovf_o
);

  logic [OUT_W:0] limit;
  logic           exp_big;
  logic           hi_nz;
  int             exp_i32;

  always_comb begin
    exp_i32 = int'(exp_i);
    exp_big = (exp_i32 >= OUT_W);
    // Bits above the result width are nonzero only when the exponent is too big.
    hi_nz   = |shifted_i[MANT_W-1:OUT_W];
    mag_o   = shifted_i[OUT_W-1:0];
    // Threshold 2^(OUT_W-1) + sign: one more magnitude allowed when negative.
    limit   = {2'b01, {(OUT_W-1){1'b0}}} + {{OUT_W{1'b0}}, sign_i};
    ovf_o   = exp_big | hi_nz | ({1'b0, mag_o} >= limit);
  end

endmodule

// File: rtl/fti_pack.sv
// Chooses the final integer and exception flags from class and range.
module fti_pack
  import fti_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic [2:0]       class_i,
  input  logic             sign_i,
  input  logic [OUT_W-1:0] mag_i,
  input  logic             sticky_i,
  input  logic             ovf_i,
  output logic [OUT_W-1:0] result_o,
  output logic             inexact_o,
  output logic             invalid_o
);

  logic [OUT_W-1:0] sat_word;
  logic [OUT_W-1:0] signed_mag;

  always_comb begin
    sat_word   = {sign_i, {(OUT_W-1){~sign_i}}};
    signed_mag = sign_i ? (~mag_i + {{(OUT_W-1){1'b0}}, 1'b1}) : mag_i;
    result_o   = sat_word;
    inexact_o  = 1'b0;
    invalid_o  = 1'b1;
    case (fti_class_e'(class_i))
      FTI_ZERO: begin
        result_o  = '0;
        invalid_o = 1'b0;
      end
      FTI_FIN: begin
        if (!ovf_i) begin
          result_o  = signed_mag;
          inexact_o = sticky_i;
          invalid_o = 1'b0;
        end
      end
      default: begin
        // Infinity, NaNs and unused codes saturate by sign.
        result_o  = sat_word;
      end
    endcase
  end

endmodule

// File: rtl/fti_trunc_conv.sv
module fti_trunc_conv
  import fti_pkg::*;
#(
  parameter int OUT_W  = 32,
  parameter int MANT_W = 66,
  parameter int EXP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_result,
  output logic                    out_inexact,
  output logic                    out_invalid
);

  localparam int SH_W = fti_shift_bits(MANT_W);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Shift distance from the mantissa's binary point to the integer LSB.
  logic [SH_W-1:0] shift_amt;
  int              shift_i32;

  always_comb begin
    shift_i32 = (MANT_W - 1) - int'(in_exp);
    if (shift_i32 > MANT_W) shift_i32 = MANT_W;  // full shift-out
    if (shift_i32 < 0)      shift_i32 = 0;       // overflow path anyway
    shift_amt = SH_W'(shift_i32);
  end

  logic [MANT_W-1:0] aligned;
  logic              sticky;
  logic [OUT_W-1:0]  magnitude;
  logic              overflow;
  logic [OUT_W-1:0]  conv_result;
  logic              conv_inexact;
  logic              conv_invalid;

  fti_align_shift #(.MANT_W(MANT_W), .SH_W(SH_W)) u_shift (
    .mant_i    (in_mant),
    .amt_i     (shift_amt),
    .shifted_o (aligned),
    .sticky_o  (sticky)
  );

  fti_range_chk #(.OUT_W(OUT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_range (
    .exp_i     (in_exp),
    .sign_i    (in_sign),
    .shifted_i (aligned),
    .mag_o     (magnitude),
    .ovf_o     (overflow)
  );

  fti_pack #(.OUT_W(OUT_W)) u_pack (
    .class_i   (in_class),
    .sign_i    (in_sign),
    .mag_i     (magnitude),
    .sticky_i  (sticky),
    .ovf_i     (overflow),
    .result_o  (conv_result),
    .inexact_o (conv_inexact),
    .invalid_o (conv_invalid)
  );

  // Next-state logic with an explicit clock enable.
  logic             valid_d;
  logic [OUT_W-1:0] result_d;
  logic             inexact_d;
  logic             invalid_d;

  always_comb begin
    valid_d   = in_valid;
    result_d  = out_result;
    inexact_d = out_inexact;
    invalid_d = out_invalid;
    if (in_valid) begin
      result_d  = conv_result;
      inexact_d = conv_inexact;
      invalid_d = conv_invalid;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      out_result  <= result_d;
      out_inexact <= inexact_d;
      out_invalid <= invalid_d;
    end
  end

  // Embedded checks.
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);
  a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> ($stable(out_result) && $stable(out_inexact) && $stable(out_invalid)));
  a_r3_zero_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && in_class == 3'd0) |=> (out_result == '0 && !out_inexact && !out_invalid));
  a_r6_neg_exp: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && in_class == 3'd1 && in_exp[EXP_W-1] && (|in_mant))
      |=> (out_result == '0 && out_inexact && !out_invalid));
  a_r9_sat_word: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_invalid |-> (!out_inexact &&
      (out_result == {1'b0, {(OUT_W-1){1'b1}}} || out_result == {1'b1, {(OUT_W-1){1'b0}}})));
  a_r10_nonnum_invalid: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && in_class >= 3'd2) |=> out_invalid);
  a_r12_flags_excl: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(out_inexact && out_invalid));

endmodule

// File: tb/fti_trunc_conv_tb.sv
module fti_trunc_conv_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OUT_W  = 32;
  localparam int MANT_W = 66;
  localparam int EXP_W  = 12;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    in_valid;
  logic [2:0]              in_class;
  logic                    in_sign;
  logic signed [EXP_W-1:0] in_exp;
  logic [MANT_W-1:0]       in_mant;
  logic                    out_valid;
  logic [OUT_W-1:0]        out_result;
  logic                    out_inexact;
  logic                    out_invalid;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fti_trunc_conv #(.OUT_W(OUT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .out_valid(out_valid),
    .out_result(out_result), .out_inexact(out_inexact), .out_invalid(out_invalid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // Arithmetic reference: value = m * 2^(e - (MANT_W-1)), truncated.
  task automatic model(input logic [2:0] c, input logic s, input int e, input logic [MANT_W-1:0] m,
                       output logic [OUT_W-1:0] r, output logic x, output logic v, output string tag);
    logic [127:0] wide, mag, rem;
    logic [OUT_W-1:0] sat;
    int sh;
    sat = s ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
    r = sat; x = 1'b0; v = 1'b1;
    if (c == 3'd0) begin
      r = '0; v = 1'b0; tag = "R3";
    end else if (c != 3'd1) begin
      tag = "R10";
    end else if (e >= OUT_W) begin
      tag = "R7";
    end else if (e < 0) begin
      r = '0; x = (m != '0); v = 1'b0; tag = "R6";
    end else begin
      sh   = MANT_W - 1 - e;
      wide = 128'(m);
      mag  = wide / (128'd1 << sh);
      rem  = wide - mag * (128'd1 << sh);
      if (mag >= (128'd1 << (OUT_W-1)) + 128'(s)) begin
        tag = "R8";
      end else begin
        r = mag[OUT_W-1:0];
        if (s) r = OUT_W'(0) - r;
        x = (rem != 0); v = 1'b0;
        tag = (rem != 0) ? "R5" : "R4";
      end
    end
  endtask

  task automatic run_one(input logic [2:0] c, input logic s, input int e, input logic [MANT_W-1:0] m);
    logic [OUT_W-1:0] er;
    logic ex, ev;
    string tag;
    model(c, s, e, m, er, ex, ev, tag);
    in_valid = 1'b1; in_class = c; in_sign = s; in_exp = EXP_W'(e); in_mant = m;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R1 valid"}, 64'(out_valid), 64'd1);
    check({tag, " result"}, 64'(out_result), 64'(er));
    check({tag, " inexact"}, 64'(out_inexact), 64'(ex));
    check({tag, " invalid"}, 64'(out_invalid), 64'(ev));
    check("R12 flags", 64'(out_inexact & out_invalid), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [MANT_W-1:0] pats [4];
    logic [OUT_W-1:0]  held_r;
    logic              held_x, held_v;
    rst_n = 1'b0; in_valid = 1'b0; in_class = 3'd1; in_sign = 1'b0;
    in_exp = '0; in_mant = '0;
    repeat (3) @(negedge clk);
    check("R11 valid", 64'(out_valid), 64'd0);
    check("R11 result", 64'(out_result), 64'd0);
    check("R11 flags", 64'({out_inexact, out_invalid}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Exponent sweep over several mantissa patterns and both signs (R4..R9).
    for (int e = -75; e <= 72; e++) begin
      pats[0] = {1'b1, {(MANT_W-1){1'b0}}};
      pats[1] = {MANT_W{1'b1}};
      pats[2] = {1'b1, {(MANT_W-2){1'b0}}, 1'b1};
      pats[3] = {1'b1, 64'(64'h9E37_79B9_7F4A_7C15 * 64'(e + 200)), 1'b0};
      for (int p = 0; p < 4; p++) begin
        for (int s = 0; s < 2; s++) begin
          run_one(3'd1, 1'(s), e, pats[p]);
        end
      end
    end

    // Boundary of R8: magnitude exactly 2^(OUT_W-1) for each sign.
    run_one(3'd1, 1'b1, OUT_W-1, {1'b1, {(MANT_W-1){1'b0}}});
    check("R8 neg min allowed", 64'(out_invalid), 64'd0);
    run_one(3'd1, 1'b0, OUT_W-1, {1'b1, {(MANT_W-1){1'b0}}});
    check("R9 pos sat", 64'(out_result), 64'(32'h7FFF_FFFF));

    // Every class code, both signs, several exponents (R3, R10).
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 2; s++) begin
        run_one(3'(c), 1'(s), -5, {MANT_W{1'b1}});
        run_one(3'(c), 1'(s), 3, {MANT_W{1'b1}});
        run_one(3'(c), 1'(s), 40, {MANT_W{1'b1}});
      end
    end

    // R2: idle cycles with changing inputs leave outputs untouched.
    run_one(3'd1, 1'b1, 10, {MANT_W{1'b1}});
    held_r = out_result; held_x = out_inexact; held_v = out_invalid;
    for (int i = 0; i < 6; i++) begin
      in_class = 3'(i); in_sign = 1'(i); in_exp = EXP_W'(i * 9 - 20); in_mant = {MANT_W{i[0]}};
      @(negedge clk);
      check("R2 hold result", 64'(out_result), 64'(held_r));
      check("R2 hold flags", 64'({out_inexact, out_invalid}), 64'({held_x, held_v}));
      check("R1 idle valid", 64'(out_valid), 64'd0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule